// File: doc/BRIEF.md
# Dual-Bank Operand Register File

This block holds the general-purpose registers of a small datapath and delivers two source operands per request. The registers are split into two banks. Each bank has one read port, and the two banks are read side by side. When the two requested registers sit in different banks, both values arrive together one cycle after the request. When they sit in the same bank, the block flags a collision. It then spends one extra cycle reading the second operand and presents the pair once both are in hand.

A request is made by raising `rd_req` with two register numbers. Bit 0 of a register number picks the bank and the remaining bits pick the entry inside that bank. During the single `stall` cycle the requester must hold off, because request inputs are not looked at. A single write port updates one register per cycle. The write lands at the clock edge and reads see it from the next cycle on.

Top module: `rfb_regfile`

## Requirements
- R1: Bit 0 of a register number selects its bank (0 for bank A, 1 for bank B). Bits above it select the entry inside that bank, so each bank holds half of the registers.
- R2: A request whose two register numbers differ in bit 0 yields both values on `op0_data`/`op1_data` with `op_valid` high in the cycle after the request, and `stall` stays low.
- R3: `conflict` is high, in the same cycle as the request, exactly when `rd_req` is high, `stall` is low, and the two register numbers differ but share bit 0.
- R4: After a conflicting request, `stall` is high for exactly one cycle. In the cycle after that, `op_valid` is high with the first register's value on `op0_data` and the second register's value on `op1_data`.
- R5: Request inputs driven while `stall` is high are ignored: they produce no result, and `op_valid` is low in any cycle that no accepted request completes in.
- R6: A request naming the same register twice is not a conflict. It completes in one cycle with the same value on both outputs.
- R7: A write commits at the clock edge and is visible to reads from the next cycle. A read requested in the same cycle as a write to that register returns the old contents.
- R8: In a conflicting request, the second operand is read in the stall cycle, so it reflects a write committed at the end of the request cycle.
- R9: Reset clears every register to zero and leaves `op_valid` and `stall` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Operand read request |
| rd_idx0 | input | IDX_W | Register number of the first operand |
| rd_idx1 | input | IDX_W | Register number of the second operand |
| wr_en | input | 1 | Write enable |
| wr_idx | input | IDX_W | Register number to write |
| wr_data | input | DATA_W | Write value |
| op0_data | output | DATA_W | First operand value |
| op1_data | output | DATA_W | Second operand value |
| op_valid | output | 1 | Operand pair valid this cycle |
| conflict | output | 1 | Same-bank collision on the current request |
| stall | output | 1 | Second read in progress; request inputs ignored |

## Verification
The bench builds the block with eight registers of 16 bits, which gives four entries per bank. With that size, every register can be written with a distinct pattern and read back through both banks and both operand slots. Every same-bank pairing of interest, as well as identical-register requests, can be reached in a few cycles. The small width keeps the patterns readable, while the bank-select and entry-address logic is the same as at the full 32-register default.

// File: rtl/rfb_pkg.sv
package rfb_pkg;

    // Sequencer phase: accept a new request, or finish a same-bank pair
    typedef enum logic {
        PH_ACCEPT = 1'b0,
        PH_SECOND = 1'b1
    } seq_phase_e;

endpackage

// File: rtl/rfb_bank.sv
// One bank of registers: one write port, one combinational read port.
module rfb_bank #(
    parameter int AW     = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 2 ** AW;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/rfb_route.sv
// Bank decode: bank select, per-bank read address, collision detection.
module rfb_route #(
    parameter int IDX_W = 5
) (
    input  logic                    req,
    input  logic                    second,
    input  logic [IDX_W-1:0]        idx0,
    input  logic [IDX_W-1:0]        idx1,
    input  logic [IDX_W-1:0]        pend_idx,
    output logic [1:0][IDX_W-2:0]   bank_addr,
    output logic                    conflict
);
    logic same_bank;
    logic same_reg;

    always_comb begin
        same_bank = (idx0[0] == idx1[0]);
        same_reg  = (idx0 == idx1);
        conflict  = req && !second && same_bank && !same_reg;

        bank_addr = '0;
        if (second) begin
            bank_addr[pend_idx[0]] = pend_idx[IDX_W-1:1];
        end else begin
            // first operand is written last so it wins its bank on a collision
            bank_addr[idx1[0]] = idx1[IDX_W-1:1];
            bank_addr[idx0[0]] = idx0[IDX_W-1:1];
        end
    end

endmodule

// File: rtl/rfb_regfile.sv
module rfb_regfile #(
    parameter int REG_COUNT = 32,
    parameter int DATA_W    = 32,
    parameter int IDX_W     = $clog2(REG_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [IDX_W-1:0]  rd_idx0,
    input  logic [IDX_W-1:0]  rd_idx1,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] op0_data,
    output logic [DATA_W-1:0] op1_data,
    output logic              op_valid,
    output logic              conflict,
    output logic              stall
);
    import rfb_pkg::*;

    localparam int LOC_W = IDX_W - 1;
    localparam int NUM_BANKS = 2;

    typedef struct packed {
        seq_phase_e        phase;
        logic [IDX_W-1:0]  pend_idx;
        logic [DATA_W-1:0] op0;
        logic [DATA_W-1:0] op1;
        logic              valid;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic [1:0][LOC_W-1:0] bank_addr;
    logic [DATA_W-1:0]     bank_rdata [NUM_BANKS];
    logic                  in_second;

    assign in_second = (st_q.phase == PH_SECOND);

    rfb_route #(.IDX_W(IDX_W)) u_route (
        .req       (rd_req),
        .second    (in_second),
        .idx0      (rd_idx0),
        .idx1      (rd_idx1),
        .pend_idx  (st_q.pend_idx),
        .bank_addr (bank_addr),
        .conflict  (conflict)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        rfb_bank #(.AW(LOC_W), .DATA_W(DATA_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_en && (wr_idx[0] == 1'(g))),
            .waddr (wr_idx[IDX_W-1:1]),
            .wdata (wr_data),
            .raddr (bank_addr[g]),
            .rdata (bank_rdata[g])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        case (st_q.phase)
            PH_ACCEPT: begin
                if (rd_req) begin
                    st_d.op0 = bank_rdata[rd_idx0[0]];
                    if (conflict) begin
                        st_d.pend_idx = rd_idx1;
                        st_d.phase    = PH_SECOND;
                    end else begin
                        st_d.op1   = bank_rdata[rd_idx1[0]];
                        st_d.valid = 1'b1;
                    end
                end
            end
            PH_SECOND: begin
                st_d.op1   = bank_rdata[st_q.pend_idx[0]];
                st_d.valid = 1'b1;
                st_d.phase = PH_ACCEPT;
            end
            default: st_d.phase = PH_ACCEPT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign op0_data = st_q.op0;
    assign op1_data = st_q.op1;
    assign op_valid = st_q.valid;
    assign stall    = in_second;

endmodule

// File: rtl/rfb_regfile_chk.sv
module rfb_regfile_chk #(
    parameter int IDX_W  = 5,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic [IDX_W-1:0]  rd_idx0,
    input logic [IDX_W-1:0]  rd_idx1,
    input logic [DATA_W-1:0] op0_data,
    input logic [DATA_W-1:0] op1_data,
    input logic              op_valid,
    input logic              conflict,
    input logic              stall
);
    // R3
    conflict_to_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |=> stall);

    // R4
    single_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    // R4
    stall_then_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> op_valid);

    // R2
    one_cycle_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !stall && !conflict) |=> (op_valid && !stall));

    // R5
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_req && !stall) |=> !op_valid);

    // R6
    same_reg_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !stall && rd_idx0 == rd_idx1) |=> (op0_data == op1_data));

    // R3
    no_conflict_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !conflict);

endmodule

bind rfb_regfile rfb_regfile_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .rd_idx0  (rd_idx0),
    .rd_idx1  (rd_idx1),
    .op0_data (op0_data),
    .op1_data (op1_data),
    .op_valid (op_valid),
    .conflict (conflict),
    .stall    (stall)
);

// File: tb/rfb_regfile_test.sv
module rfb_regfile_test;
    localparam int REGS = 8;
    localparam int DW   = 16;
    localparam int IW   = $clog2(REGS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_req = 1'b0;
    logic [IW-1:0] rd_idx0 = '0;
    logic [IW-1:0] rd_idx1 = '0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] op0_data, op1_data;
    logic          op_valid, conflict, stall;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [DW-1:0] model [REGS];

    always #5 clk = ~clk;

    rfb_regfile #(.REG_COUNT(REGS), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_idx0(rd_idx0),
        .rd_idx1(rd_idx1), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .op0_data(op0_data), .op1_data(op1_data), .op_valid(op_valid),
        .conflict(conflict), .stall(stall)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pattern(input int i);
        return DW'(16'hA000 + i * 16'h0111);
    endfunction

    // Read request with optional same-cycle write and optional noise in the stall cycle
    task automatic read_pair(input int s0, input int s1, input bit w, input int wi,
                             input logic [DW-1:0] wd, input bit noise, input string req);
        logic [DW-1:0] e0, e1;
        bit exp_conf;
        exp_conf = (s0 % 2 == s1 % 2) && (s0 != s1);
        e0 = model[s0];
        e1 = model[s1];
        @(negedge clk);
        rd_req = 1'b1; rd_idx0 = IW'(s0); rd_idx1 = IW'(s1);
        wr_en = w; wr_idx = IW'(wi); wr_data = wd;
        #1;
        check(conflict == exp_conf, req, "conflict flag", DW'(conflict), DW'(exp_conf));
        if (w) model[wi] = wd;
        @(negedge clk);
        wr_en = 1'b0;
        if (exp_conf) begin
            if (w && wi == s1) e1 = wd;  // second read happens after the write
            if (noise) begin
                rd_idx0 = IW'((s0 + 1) % REGS); rd_idx1 = IW'((s1 + 2) % REGS);
            end else begin
                rd_req = 1'b0;
            end
            check(stall == 1'b1 && op_valid == 1'b0, req, "stall cycle",
                  DW'({stall, op_valid}), DW'(2'b10));
            @(negedge clk);
            rd_req = 1'b0;
        end else begin
            rd_req = 1'b0;
        end
        check(op_valid == 1'b1 && stall == 1'b0, req, "valid/stall",
              DW'({op_valid, stall}), DW'(2'b10));
        check(op0_data == e0, req, "op0", op0_data, e0);
        check(op1_data == e1, req, "op1", op1_data, e1);
    endtask

    task automatic write_reg(input int i, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IW'(i); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model[i] = d;
    endtask

    task automatic t_reset;
        check(op_valid == 1'b0 && stall == 1'b0, "R9", "flags after reset",
              DW'({op_valid, stall}), '0);
        for (int i = 0; i < REGS; i += 2) begin
            read_pair(i, i + 1, 1'b0, 0, '0, 1'b0, "R9");
        end
    endtask

    task automatic t_cross_bank;
        for (int i = 0; i < REGS; i++) write_reg(i, pattern(i));
        read_pair(0, 1, 1'b0, 0, '0, 1'b0, "R2");
        read_pair(3, 6, 1'b0, 0, '0, 1'b0, "R2");
        read_pair(7, 2, 1'b0, 0, '0, 1'b0, "R1");
        read_pair(4, 5, 1'b0, 0, '0, 1'b0, "R1");
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        rd_req = 1'b1; rd_idx0 = 3'd2; rd_idx1 = 3'd5;
        @(negedge clk);
        check(op_valid && op0_data == model[2] && op1_data == model[5], "R2",
              "first of pair", op1_data, model[5]);
        rd_idx0 = 3'd6; rd_idx1 = 3'd1;
        @(negedge clk);
        rd_req = 1'b0;
        check(op_valid && op0_data == model[6] && op1_data == model[1], "R2",
              "second of pair", op0_data, model[6]);
    endtask

    task automatic t_conflict;
        read_pair(2, 4, 1'b0, 0, '0, 1'b0, "R4");
        read_pair(7, 1, 1'b0, 0, '0, 1'b0, "R4");
        read_pair(6, 0, 1'b0, 0, '0, 1'b0, "R3");
    endtask

    task automatic t_stall_ignore;
        read_pair(3, 5, 1'b0, 0, '0, 1'b1, "R5");
        @(negedge clk);
        check(op_valid == 1'b0, "R5", "no result from stall-cycle inputs",
              DW'(op_valid), '0);
    endtask

    task automatic t_same_reg;
        read_pair(5, 5, 1'b0, 0, '0, 1'b0, "R6");
        read_pair(0, 0, 1'b0, 0, '0, 1'b0, "R6");
    endtask

    task automatic t_write_timing;
        logic [DW-1:0] old3;
        old3 = model[3];
        read_pair(3, 0, 1'b1, 3, 16'h5A5A, 1'b0, "R7");
        check(op0_data == old3, "R7", "same-cycle read sees old value", op0_data, old3);
        read_pair(3, 0, 1'b0, 0, '0, 1'b0, "R7");
    endtask

    task automatic t_conflict_write;
        read_pair(1, 3, 1'b1, 3, 16'hC3C3, 1'b0, "R8");
        check(op1_data == 16'hC3C3, "R8", "second operand after write",
              op1_data, 16'hC3C3);
    endtask

    initial begin
        for (int i = 0; i < REGS; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cross_bank();
        t_back_to_back();
        t_conflict();
        t_stall_ignore();
        t_same_reg();
        t_write_timing();
        t_conflict_write();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule